// File: doc/BRIEF.md
# Dual-Word Serial Output Emulator

This block plays the device side of a two-channel sampling converter's serial data port. A test environment supplies two result words. The block responds to a convert-start strobe with a busy pulse of programmable length, and then presents the results on two serial data lines that a host controller reads with a chip select and a serial clock. It is meant to stand in for the real converter when a host-side reader is exercised in simulation or in a hardware loopback. No analog behaviour is modelled.

All strobes coming from the host (convert-start, chip select and serial clock) are asynchronous to the system clock. Each passes through a synchronizer, and edges are detected in the system clock domain. Each data line has its own enable that stands for a tri-state driver. While chip select is low, each line first carries its own channel's word and then the other channel's word. After that it holds zero until chip select is released.

Top module: `dual_word_sout`

## Requirements
- R1: After reset, busy is low, both enables are low and both data lines are low.
- R2: A falling edge on `conv_n` while idle captures `word_a_i` and `word_b_i` and raises `busy`. `busy` stays high for exactly `conv_cycles` system clock cycles, or for 1 cycle when `conv_cycles` is 0. Changes to the word inputs after the capture have no effect on the result.
- R3: A falling edge on `conv_n` while `busy` is high is ignored. The busy duration and the captured words remain those of the first strobe.
- R4: When chip select falls, both enables go high. With no serial clock edge yet, `sdo_a` shows bit 11 of word A and `sdo_b` shows bit 11 of word B.
- R5: Each later serial clock falling edge moves each line to the next lower bit of its own word, most significant bit first, for 12 bits.
- R6: On the 12th through 23rd falling edges, `sdo_a` carries word B and `sdo_b` carries word A, again most significant bit first.
- R7: From the 24th falling edge onward, both lines drive 0 while chip select stays low, whatever further edges arrive.
- R8: A serial clock falling edge that reaches the synchronizers in the same system clock cycle as the chip select falling edge does not advance the bit position.
- R9: While chip select is high, both enables and both data lines are low. The next chip-select assertion starts again from bit 11 of the current result.
- R10: While `busy` is high, both data lines drive 0, and serial clock edges do not advance the bit position. If chip select is already low when `busy` falls, the most significant bits appear on the lines in the cycle `busy` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n | input | 1 | Convert-start strobe; a falling edge starts a conversion |
| conv_cycles | input | CONV_W | Conversion time in system clock cycles |
| word_a_i | input | WORD_W | Result word for channel A |
| word_b_i | input | WORD_W | Result word for channel B |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host; data advances on falling edges |
| busy_o | output | 1 | High while a conversion is in progress |
| sdo_a | output | 1 | Serial data line A |
| sdo_b | output | 1 | Serial data line B |
| sdo_a_en | output | 1 | Drive enable for line A (low means high impedance) |
| sdo_b_en | output | 1 | Drive enable for line B (low means high impedance) |

## Verification
On every cycle, the assertions check the following invariants: the lines stay quiet while chip select is high or a conversion runs, the bit position never exceeds 24 and moves only by single steps or back to zero, the lines are zero once 24 bits have been sent, and busy rises only after a detected convert-start edge. Some behaviour needs concrete words and timings, so only the bench scenarios can show it. That covers the exact busy length for each programmed time, the cross-over to the other channel's word, the discarded coincident clock edge, the ignored second strobe, and the most significant bit appearing as busy falls.

// File: rtl/dws_pkg.sv
package dws_pkg;

    // Events seen by the core after synchronisation to the system clock.
    typedef struct packed {
        logic conv_fall;
        logic cs_low;
        logic cs_fall;
        logic sclk_fall;
    } dws_evt_t;

    // Lane order inside the synchronizer bank.
    localparam int unsigned LANE_CONV = 0;
    localparam int unsigned LANE_CS   = 1;
    localparam int unsigned LANE_SCLK = 2;
    localparam int unsigned LANES     = 3;

endpackage

// File: rtl/dws_sync.sv
module dws_sync
    import dws_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     conv_n,
    input  logic     cs_n,
    input  logic     sclk,
    output dws_evt_t evt
);

    logic [LANES-1:0] raw;
    logic [LANES-1:0] lvl;
    logic [LANES-1:0] fall;

    assign raw[LANE_CONV] = conv_n;
    assign raw[LANE_CS]   = cs_n;
    assign raw[LANE_SCLK] = sclk;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        typedef struct packed {
            logic [STAGES-1:0] pipe;
            logic              prev;
        } lane_t;

        lane_t lane_d, lane_q;

        always_comb begin
            lane_d      = lane_q;
            lane_d.pipe = {lane_q.pipe[STAGES-2:0], raw[i]};
            lane_d.prev = lane_q.pipe[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lane_q <= '1;
            else        lane_q <= lane_d;
        end

        assign lvl[i]  = lane_q.pipe[STAGES-1];
        assign fall[i] = lane_q.prev & ~lane_q.pipe[STAGES-1];
    end

    assign evt.conv_fall = fall[LANE_CONV];
    assign evt.cs_low    = ~lvl[LANE_CS];
    assign evt.cs_fall   = fall[LANE_CS];
    assign evt.sclk_fall = fall[LANE_SCLK];

endmodule

// File: rtl/dws_conv_timer.sv
module dws_conv_timer #(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_fall,
    input  logic [CNT_W-1:0]  conv_cycles,
    input  logic [WORD_W-1:0] word_a_i,
    input  logic [WORD_W-1:0] word_b_i,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] res_a,
    output logic [WORD_W-1:0] res_b
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] pend_a;
        logic [WORD_W-1:0] pend_b;
        logic [WORD_W-1:0] res_a;
        logic [WORD_W-1:0] res_b;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = 1'b0;
        if (tmr_q.busy) begin
            // Strobes arriving mid-conversion fall through to nothing.
            if (tmr_q.cnt <= ONE) begin
                tmr_d.busy  = 1'b0;
                tmr_d.cnt   = '0;
                tmr_d.res_a = tmr_q.pend_a;
                tmr_d.res_b = tmr_q.pend_b;
                done        = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - ONE;
            end
        end else if (conv_fall) begin
            tmr_d.busy   = 1'b1;
            tmr_d.cnt    = (conv_cycles == '0) ? ONE : conv_cycles;
            tmr_d.pend_a = word_a_i;
            tmr_d.pend_b = word_b_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy  = tmr_q.busy;
    assign res_a = tmr_q.res_a;
    assign res_b = tmr_q.res_b;

endmodule

// File: rtl/dws_shifter.sv
module dws_shifter #(
    parameter int unsigned WORD_W = 12,
    parameter int unsigned BIT_W  = $clog2(2 * WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              sclk_fall,
    input  logic              busy,
    input  logic              done,
    input  logic [WORD_W-1:0] res_a,
    input  logic [WORD_W-1:0] res_b,
    output logic              sdo_a,
    output logic              sdo_b,
    output logic              en_a,
    output logic              en_b,
    output logic [BIT_W-1:0]  bit_cnt
);

    localparam int unsigned     TOTAL = 2 * WORD_W;
    localparam logic [BIT_W-1:0] LAST = BIT_W'(TOTAL);
    localparam logic [BIT_W-1:0] STEP = BIT_W'(1);

    typedef struct packed {
        logic [BIT_W-1:0] cnt;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (!cs_low || done) begin
            shf_d.cnt = '0;
        end else if (sclk_fall && !cs_fall && !busy && shf_q.cnt < LAST) begin
            shf_d.cnt = shf_q.cnt + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    // Lane 0 sends A then B, lane 1 sends B then A.
    logic [1:0][TOTAL-1:0] frame;
    logic [1:0]            sdo;

    assign frame[0] = {res_a, res_b};
    assign frame[1] = {res_b, res_a};

    for (genvar c = 0; c < 2; c++) begin : g_out
        logic [TOTAL-1:0] shifted;
        assign shifted = frame[c] << shf_q.cnt;
        assign sdo[c]  = cs_low & ~busy & shifted[TOTAL-1];
    end

    assign sdo_a   = sdo[0];
    assign sdo_b   = sdo[1];
    assign en_a    = cs_low;
    assign en_b    = cs_low;
    assign bit_cnt = shf_q.cnt;

endmodule

// File: rtl/dual_word_sout.sv
module dual_word_sout
    import dws_pkg::*;
#(
    parameter int unsigned WORD_W      = 12,
    parameter int unsigned CONV_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_n,
    input  logic [CONV_W-1:0] conv_cycles,
    input  logic [WORD_W-1:0] word_a_i,
    input  logic [WORD_W-1:0] word_b_i,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              busy_o,
    output logic              sdo_a,
    output logic              sdo_b,
    output logic              sdo_a_en,
    output logic              sdo_b_en
);

    localparam int unsigned BIT_W = $clog2(2 * WORD_W + 1);

    dws_evt_t          evt;
    logic              busy;
    logic              done;
    logic [WORD_W-1:0] res_a;
    logic [WORD_W-1:0] res_b;
    logic [BIT_W-1:0]  bit_cnt;

    dws_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .conv_n (conv_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .evt    (evt)
    );

    dws_conv_timer #(
        .WORD_W (WORD_W),
        .CNT_W  (CONV_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_fall   (evt.conv_fall),
        .conv_cycles (conv_cycles),
        .word_a_i    (word_a_i),
        .word_b_i    (word_b_i),
        .busy        (busy),
        .done        (done),
        .res_a       (res_a),
        .res_b       (res_b)
    );

    dws_shifter #(
        .WORD_W (WORD_W),
        .BIT_W  (BIT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (evt.cs_low),
        .cs_fall   (evt.cs_fall),
        .sclk_fall (evt.sclk_fall),
        .busy      (busy),
        .done      (done),
        .res_a     (res_a),
        .res_b     (res_b),
        .sdo_a     (sdo_a),
        .sdo_b     (sdo_b),
        .en_a      (sdo_a_en),
        .en_b      (sdo_b_en),
        .bit_cnt   (bit_cnt)
    );

    assign busy_o = busy;

endmodule

// File: rtl/dws_chk.sv
module dws_chk #(
    parameter int unsigned TOTAL = 24,
    parameter int unsigned CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          conv_fall,
    input logic          cs_low,
    input logic          sdo_a,
    input logic          sdo_b,
    input logic          en_a,
    input logic          en_b,
    input logic [CW-1:0] bit_cnt
);

    localparam logic [CW-1:0] LAST = CW'(TOTAL);

    // R9
    cs_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |-> (!en_a && !en_b && !sdo_a && !sdo_b));

    // R9
    cs_high_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> (bit_cnt == '0));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST);

    // R7
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == LAST) |-> (!sdo_a && !sdo_b));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt != $past(bit_cnt)) |-> ((bit_cnt == $past(bit_cnt) + CW'(1)) || (bit_cnt == '0)));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!sdo_a && !sdo_b));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((bit_cnt == $past(bit_cnt)) || (bit_cnt == '0)));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(conv_fall));

endmodule

bind dual_word_sout dws_chk #(
    .TOTAL (2 * WORD_W),
    .CW    (BIT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .conv_fall (evt.conv_fall),
    .cs_low    (evt.cs_low),
    .sdo_a     (sdo_a),
    .sdo_b     (sdo_b),
    .en_a      (sdo_a_en),
    .en_b      (sdo_b_en),
    .bit_cnt   (bit_cnt)
);

// File: tb/dual_word_sout_tb.sv
module dual_word_sout_tb;

    localparam int W  = 12;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_n = 1'b1;
    logic [CW-1:0] conv_cycles = '0;
    logic [W-1:0]  word_a_i = '0;
    logic [W-1:0]  word_b_i = '0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b1;
    logic          busy_o, sdo_a, sdo_b, sdo_a_en, sdo_b_en;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dual_word_sout u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_n      (conv_n),
        .conv_cycles (conv_cycles),
        .word_a_i    (word_a_i),
        .word_b_i    (word_b_i),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .busy_o      (busy_o),
        .sdo_a       (sdo_a),
        .sdo_b       (sdo_b),
        .sdo_a_en    (sdo_a_en),
        .sdo_b_en    (sdo_b_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Start a conversion and count the cycles busy is high.
    task automatic convert(input logic [W-1:0] a, input logic [W-1:0] b,
                           input int cyc, output int seen);
        word_a_i = a; word_b_i = b; conv_cycles = CW'(cyc);
        conv_n = 1'b0;
        seen = 0;
        for (int i = 0; i < cyc + 20; i++) begin
            tick(1);
            if (busy_o) seen++;
            if (i == 4) begin
                word_a_i = ~a; word_b_i = ~b;   // after capture: must not matter
            end
        end
        conv_n = 1'b1;
        tick(4);
    endtask

    task automatic read_frame(output logic [2*W-1:0] fa, output logic [2*W-1:0] fb,
                              output logic en_ok, output logic tail0, output logic off_ok);
        cs_n = 1'b0; tick(4);
        en_ok = sdo_a_en & sdo_b_en;
        fa[2*W-1] = sdo_a; fb[2*W-1] = sdo_b;
        for (int k = 1; k < 2*W; k++) begin
            sclk = 1'b0; tick(4);
            fa[2*W-1-k] = sdo_a; fb[2*W-1-k] = sdo_b;
            sclk = 1'b1; tick(4);
        end
        tail0 = 1'b1;
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b0; tick(4);
            tail0 &= !sdo_a && !sdo_b && sdo_a_en;
            sclk = 1'b1; tick(4);
        end
        cs_n = 1'b1; tick(4);
        off_ok = !sdo_a_en && !sdo_b_en && !sdo_a && !sdo_b;
    endtask

    initial begin
        logic [2*W-1:0] fa, fb, fa2, fb2;
        logic en_ok, tail0, off_ok;
        int seen;
        logic [W-1:0] a, b;

        tick(3);
        // R1 reset state
        check("R1 busy", busy_o, 0);
        check("R1 enables", {sdo_a_en, sdo_b_en}, 0);
        check("R1 data", {sdo_a, sdo_b}, 0);
        rst_n = 1'b1;
        tick(3);
        check("R1 idle after release", {busy_o, sdo_a_en, sdo_b_en, sdo_a, sdo_b}, 0);

        // Sweep of word pairs and conversion times.
        for (int p = 0; p < 8; p++) begin
            int cyc;
            a = W'((p * 2531 + 291) % 4096);
            b = W'((p * 1433 + 3000) % 4096);
            if (p == 0) begin a = '1; b = '0; end
            if (p == 1) begin a = 12'hA5A; b = 12'h5A5; end
            cyc = (p == 2) ? 0 : p * 3 + 1;
            convert(a, b, cyc, seen);
            check("R2 busy length", seen, (cyc == 0) ? 1 : cyc);
            read_frame(fa, fb, en_ok, tail0, off_ok);
            check("R4 enables on cs fall", en_ok, 1);
            check("R4 msb line A", fa[2*W-1], a[W-1]);
            check("R4 msb line B", fb[2*W-1], b[W-1]);
            check("R5 and R2 own word line A", fa[2*W-1:W], a);
            check("R5 own word line B", fb[2*W-1:W], b);
            check("R6 other word line A", fa[W-1:0], b);
            check("R6 other word line B", fb[W-1:0], a);
            check("R7 zeros after 24 bits", tail0, 1);
            check("R9 off when cs high", off_ok, 1);
            read_frame(fa2, fb2, en_ok, tail0, off_ok);
            check("R9 reread restarts line A", fa2, fa);
            check("R9 reread restarts line B", fb2, fb);
        end

        // R3: second strobe during busy is ignored.
        begin
            int cnt = 0;
            word_a_i = 12'h3C1; word_b_i = 12'h8E7; conv_cycles = CW'(20);
            conv_n = 1'b0;
            for (int i = 0; i < 60; i++) begin
                tick(1);
                if (busy_o) cnt++;
                if (i == 6) begin
                    conv_n = 1'b1; word_a_i = 12'h111; word_b_i = 12'h222;
                    conv_cycles = CW'(40);
                end
                if (i == 9) conv_n = 1'b0;
            end
            conv_n = 1'b1; tick(4);
            check("R3 busy length unchanged", cnt, 20);
            read_frame(fa, fb, en_ok, tail0, off_ok);
            check("R3 words from first strobe A", fa[2*W-1:W], 12'h3C1);
            check("R3 words from first strobe B", fb[2*W-1:W], 12'h8E7);
        end

        // R8: coincident sclk and cs falls; the edge is not counted.
        a = 12'h3C1;
        cs_n = 1'b0; sclk = 1'b0; tick(4);
        check("R8 coincident edge ignored", sdo_a, a[W-1]);
        sclk = 1'b1; tick(4);
        sclk = 1'b0; tick(4);
        check("R8 next edge is first bit", sdo_a, a[W-2]);
        sclk = 1'b1; tick(4);
        sclk = 1'b0; tick(4);
        check("R8 second bit", sdo_a, a[W-3]);
        sclk = 1'b1; cs_n = 1'b1; tick(4);

        // R10: chip select held low across a conversion.
        begin
            int guard;
            a = 12'h9B4; b = 12'h4D2;
            cs_n = 1'b0; tick(4);
            word_a_i = a; word_b_i = b; conv_cycles = CW'(40);
            conv_n = 1'b0;
            guard = 0;
            while (!busy_o && guard < 20) begin tick(1); guard++; end
            check("R10 busy seen", busy_o, 1);
            check("R10 data zero while busy", {sdo_a, sdo_b}, 0);
            check("R10 enable high while busy", sdo_a_en, 1);
            for (int k = 0; k < 2; k++) begin
                sclk = 1'b0; tick(4); sclk = 1'b1; tick(4);
            end
            check("R10 still zero while busy", {sdo_a, sdo_b}, 0);
            guard = 0;
            while (busy_o && guard < 100) begin tick(1); guard++; end
            check("R10 msb A at busy fall", sdo_a, a[W-1]);
            check("R10 msb B at busy fall", sdo_b, b[W-1]);
            sclk = 1'b0; tick(4);
            check("R10 then R5 next bit A", sdo_a, a[W-2]);
            check("R10 then R5 next bit B", sdo_b, b[W-2]);
            sclk = 1'b1; conv_n = 1'b1; cs_n = 1'b1; tick(4);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule